// File: doc/BRIEF.md
# Serial Boot Stream Transmitter

This block pushes a processor boot image out over a three-wire synchronous serial link: a serial clock, a data line and a frame-sync line. The image is first written word by word into an internal memory through a simple write port. A one-cycle pulse on `start` makes the block walk the image and send every word as a framed 32-bit serial word. The serial clock comes from an internal phase divider.

The image has a block structure. The two leading words describe the memory bus of a parallel boot device, and the serial path has no use for them, so they are never sent. Transmission starts at word index 2. From there the image is a chain of blocks. Each block is a length word, then an address word, then as many data words as the length states. A length word equal to zero is sent as the closing word and ends the stream. After it, `done` is raised.

Each word begins with two serial clock cycles of frame sync and then carries its 32 bits, most significant bit first. The transmitter changes frame sync and data on the falling clock edge, and the receiver samples on the rising edge. Between words the clock rests low for a programmable number of idle serial periods.

Top module: `boot_stream_tx`

## Requirements
- R1: After a synchronous active-high reset, `ser_clk`, `ser_sync`, `ser_data`, `busy` and `done` are all 0.
- R2: Each transmitted word is 32 bits, sent most significant bit first. Data changes only while `ser_clk` is low, so a receiver sampling on the rising edge reads bit 31 on the third rising edge of the frame and bit 0 on the 34th.
- R3: Frame sync is high on exactly the first two rising edges of every word, and `ser_data` is 0 while it is high. Frame sync is low on the rising edge that carries bit 31.
- R4: All three link lines are active high. Whenever no word is in flight, `ser_clk` is held low and `ser_data` is 0.
- R5: Image words 0 and 1 are never transmitted. The first word sent after `start` is image word 2.
- R6: The sent stream follows the block format: a length word L, an address word, then exactly L data words, repeated. A data word of value zero does not end the stream.
- R7: A length word of zero is transmitted and then ends the stream. No further word follows. `done` rises only after that word's last bit and stays high until the next accepted `start`.
- R8: Every high phase of `ser_clk` lasts exactly HALF_DIV system clock cycles, and every low phase lasts at least HALF_DIV. A HALF_DIV value below 3 is raised to 3.
- R9: Between two consecutive words, `ser_clk` stays low for at least GAP full serial periods plus one low phase, with `ser_sync` and `ser_data` at 0.
- R10: `img_we` stores `img_wdata` at `img_addr`. `busy` is 1 from the cycle after an accepted `start` until `done` rises. A `start` pulse while `busy` is 1 has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| img_we | input | 1 | Image memory write enable |
| img_addr | input | AW (clog2 of DEPTH, 6 by default) | Image memory write address |
| img_wdata | input | 32 | Image memory write data |
| start | input | 1 | Begin transmission (ignored while busy) |
| busy | output | 1 | Stream in progress |
| done | output | 1 | Closing zero-length word has been sent |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_sync | output | 1 | Frame sync, active high |

## Verification
The assertions assume that the image holds a well-formed block chain ending in a zero length word, and that the pointer never wraps past the last memory entry. They also assume the image is not rewritten while `busy` is high. The random images are built so that every block and the closing word fit inside the memory depth. Lengths are kept between 1 and 4, so the walker never reads back into the header words. Image loading always happens before `start`, and the only stimulus given during a run is a stray `start` pulse.

// File: rtl/boot_tx_pkg.sv
package boot_tx_pkg;

    localparam int WORD_BITS    = 32;
    localparam int SYNC_CYCLES  = 2;
    localparam int HEADER_WORDS = 2;
    localparam int FRAME_CYCLES = SYNC_CYCLES + WORD_BITS;
    localparam int MIN_HALF     = 3;

    typedef logic [WORD_BITS-1:0] word_t;

    typedef enum logic [1:0] {K_LEN, K_ADDR, K_DATA} kind_e;

    typedef enum logic [2:0] {W_IDLE, W_READ, W_LOAD, W_SEND, W_DONE} walk_e;

    typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} shift_e;

    typedef struct packed {
        logic sck;
        logic fs;
        logic dat;
    } line_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int eff_half(input int h);
        return (h < MIN_HALF) ? MIN_HALF : h;
    endfunction

endpackage

// File: rtl/image_ram.sv
module image_ram
    import boot_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_data
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/bit_shifter.sv
module bit_shifter
    import boot_tx_pkg::*;
#(
    parameter int HALF_DIV = 3,
    parameter int GAP      = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t word_i,
    output line_t line_o,
    output logic  fin_o
);

    localparam int HALF    = eff_half(HALF_DIV);
    localparam int HW      = cnt_w(HALF);
    localparam int CW      = cnt_w(FRAME_CYCLES);
    localparam int GAP_CYC = GAP * 2 * HALF;
    localparam int GW      = cnt_w(GAP_CYC + 1);

    shift_e        st;
    logic [HW-1:0] hc;
    logic          ph;
    logic [CW-1:0] cyc;
    word_t         sh;
    logic [GW-1:0] gc;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            hc    <= '0;
            ph    <= 1'b0;
            cyc   <= '0;
            sh    <= '0;
            gc    <= '0;
            fin_o <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (load) begin
                        st  <= S_FRAME;
                        hc  <= '0;
                        ph  <= 1'b0;
                        cyc <= '0;
                        sh  <= word_i;
                    end
                end
                S_FRAME: begin
                    if (hc == HW'(HALF - 1)) begin
                        hc <= '0;
                        ph <= ~ph;
                        if (ph) begin
                            if (cyc >= CW'(SYNC_CYCLES)) begin
                                sh <= {sh[WORD_BITS-2:0], 1'b0};
                            end
                            if (cyc == CW'(FRAME_CYCLES - 1)) begin
                                cyc <= '0;
                                if (GAP_CYC == 0) begin
                                    st    <= S_IDLE;
                                    fin_o <= 1'b1;
                                end else begin
                                    st <= S_GAP;
                                    gc <= '0;
                                end
                            end else begin
                                cyc <= cyc + 1'b1;
                            end
                        end
                    end else begin
                        hc <= hc + 1'b1;
                    end
                end
                S_GAP: begin
                    if (int'(gc) == GAP_CYC - 1) begin
                        st    <= S_IDLE;
                        fin_o <= 1'b1;
                    end else begin
                        gc <= gc + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        line_o.sck = (st == S_FRAME) && ph;
        line_o.fs  = (st == S_FRAME) && (cyc < CW'(SYNC_CYCLES));
        line_o.dat = (st == S_FRAME) && (cyc >= CW'(SYNC_CYCLES)) && sh[WORD_BITS-1];
    end

    // R3: data stays low while frame sync is asserted
    p_sync_data_low_r3: assert property (@(posedge clk) disable iff (rst)
        line_o.fs |-> !line_o.dat);

    // R3: frame sync drops only at the start of the first data cycle, clock low
    p_sync_drop_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(line_o.fs) |-> (!line_o.sck && cyc == CW'(SYNC_CYCLES)));

    // R9: the gap between words keeps all link lines quiet
    p_gap_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_GAP) |-> (line_o == '0));

    // R10: the walker only hands over a word when the shifter is free
    p_load_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        load |-> (st == S_IDLE));

    // R8: a high phase is never cut short by a new load
    p_high_phase_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(line_o.sck) |=> (line_o.sck || HALF == 1));

endmodule

// File: rtl/stream_walker.sv
module stream_walker
    import boot_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  word_t         rd_data,
    output logic          load,
    output word_t         word_o,
    input  logic          fin,
    output logic          busy,
    output logic          done
);

    walk_e         st;
    kind_e         kind;
    logic [AW-1:0] ptr;
    word_t         cur;
    word_t         remain;
    logic [AW-1:0] ptr_nxt;

    assign ptr_nxt = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= W_IDLE;
            kind   <= K_LEN;
            ptr    <= '0;
            cur    <= '0;
            remain <= '0;
        end else begin
            case (st)
                W_IDLE, W_DONE: begin
                    if (start) begin
                        st   <= W_READ;
                        ptr  <= AW'(HEADER_WORDS);
                        kind <= K_LEN;
                    end
                end
                W_READ: st <= W_LOAD;
                W_LOAD: begin
                    cur <= rd_data;
                    st  <= W_SEND;
                end
                W_SEND: begin
                    if (fin) begin
                        ptr <= ptr_nxt;
                        st  <= W_READ;
                        case (kind)
                            K_LEN: begin
                                if (cur == '0) begin
                                    st <= W_DONE;
                                end else begin
                                    remain <= cur;
                                    kind   <= K_ADDR;
                                end
                            end
                            K_ADDR: kind <= K_DATA;
                            default: begin
                                remain <= remain - 1'b1;
                                if (remain == word_t'(1)) begin
                                    kind <= K_LEN;
                                end
                            end
                        endcase
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    assign rd_en   = (st == W_READ);
    assign rd_addr = ptr;
    assign load    = (st == W_LOAD);
    assign word_o  = rd_data;
    assign busy    = (st == W_READ) || (st == W_LOAD) || (st == W_SEND);
    assign done    = (st == W_DONE);

    // R5: header words are never fetched for transmission
    p_hdr_skip_r5: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr >= AW'(HEADER_WORDS)));

    // R10: while a word is in flight, start cannot move the walker
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st == W_SEND && !fin) |=> ($stable(ptr) && $stable(kind)));

    // R7: done rises only after a zero length word has completed
    p_done_after_zero_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(kind) == K_LEN && $past(cur) == '0 && $past(fin)));

endmodule

// File: rtl/boot_stream_tx.sv
module boot_stream_tx
    import boot_tx_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int HALF_DIV = 3,
    parameter int GAP      = 2,
    localparam int AW      = cnt_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          img_we,
    input  logic [AW-1:0] img_addr,
    input  logic [31:0]   img_wdata,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          ser_clk,
    output logic          ser_data,
    output logic          ser_sync
);

    logic          rd_en;
    logic [AW-1:0] rd_addr;
    word_t         rd_data;
    logic          load;
    word_t         ld_word;
    logic          fin;
    line_t         line;

    image_ram #(.DEPTH(DEPTH), .AW(AW)) i_ram (
        .clk     (clk),
        .wr_en   (img_we),
        .wr_addr (img_addr),
        .wr_data (img_wdata),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    stream_walker #(.DEPTH(DEPTH), .AW(AW)) i_walk (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .load    (load),
        .word_o  (ld_word),
        .fin     (fin),
        .busy    (busy),
        .done    (done)
    );

    bit_shifter #(.HALF_DIV(HALF_DIV), .GAP(GAP)) i_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .word_i (ld_word),
        .line_o (line),
        .fin_o  (fin)
    );

    assign ser_clk  = line.sck;
    assign ser_data = line.dat;
    assign ser_sync = line.fs;

    // R4: with no stream running the link is idle low
    p_idle_low_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_clk && !ser_sync && !ser_data));

    // R7: done and busy are never both high
    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

endmodule

// File: tb/test_boot_stream_tx.sv
module test_boot_stream_tx;

    localparam int DEPTH = 64;
    localparam int HALF  = 3;
    localparam int GAP   = 2;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          img_we = 1'b0;
    logic [AW-1:0] img_addr = '0;
    logic [31:0]   img_wdata = '0;
    logic          start = 1'b0;
    logic          busy, done, ser_clk, ser_data, ser_sync;

    always #5 clk = ~clk;

    boot_stream_tx #(.DEPTH(DEPTH), .HALF_DIV(HALF), .GAP(GAP)) i_boot_stream_tx (
        .clk       (clk),
        .rst       (rst),
        .img_we    (img_we),
        .img_addr  (img_addr),
        .img_wdata (img_wdata),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_sync  (ser_sync)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] img   [DEPTH];
    logic [31:0] exp_w [256];
    int          exp_n;

    // receiver model
    logic [31:0] cap [1024];
    int cap_n = 0;
    int sync_err = 0, phase_err = 0, gap_err = 0, idle_err = 0;
    int run = 0, rx_fs = 0, rx_bits = 0;
    bit in_word = 0, after_word = 0, pclk = 0;
    logic [31:0] rx_sh = '0;

    always @(negedge clk) begin
        if (rst) begin
            pclk = 0;
            run  = 0;
        end else begin
            if (ser_clk != pclk) begin
                if (ser_clk) begin
                    if (run < HALF) phase_err++;
                    if (ser_sync) begin
                        if (rx_bits != 0 || ser_data) sync_err++;
                        if (rx_fs == 0 && run < HALF * (2 * GAP + 1)) gap_err++;
                        rx_fs++;
                        in_word = 1;
                    end else if (in_word) begin
                        if (rx_bits == 0 && rx_fs != 2) sync_err++;
                        rx_sh = {rx_sh[30:0], ser_data};
                        rx_bits++;
                        if (rx_bits == 32) begin
                            cap[cap_n] = rx_sh;
                            cap_n++;
                            in_word = 0;
                            rx_fs = 0;
                            rx_bits = 0;
                            after_word = 1;
                        end
                    end else begin
                        sync_err++;
                    end
                end else begin
                    if (run != HALF) phase_err++;
                    after_word = 0;
                end
                run = 1;
            end else begin
                run++;
            end
            if (!in_word && !after_word && ser_data) idle_err++;
            pclk = ser_clk;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic void build_expected();
        int p = 2;
        exp_n = 0;
        forever begin
            logic [31:0] len = img[p];
            exp_w[exp_n++] = len;
            p++;
            if (len == 0) break;
            exp_w[exp_n++] = img[p++];
            for (int k = 0; k < int'(len); k++) exp_w[exp_n++] = img[p++];
        end
    endfunction

    task automatic load_image();
        for (int a = 0; a < DEPTH; a++) begin
            img_we    = 1'b1;
            img_addr  = AW'(a);
            img_wdata = img[a];
            @(posedge clk); #1;
        end
        img_we = 1'b0;
        build_expected();
    endtask

    task automatic random_image();
        int p = 2;
        int nb = $urandom_range(1, 4);
        for (int a = 0; a < DEPTH; a++) img[a] = $urandom();
        for (int b = 0; b < nb; b++) begin
            int len = $urandom_range(1, 4);
            img[p++] = 32'(len);
            img[p++] = 32'h0080_0000 | ($urandom() & 32'hFFFF);
            for (int k = 0; k < len; k++)
                img[p++] = ($urandom_range(0, 5) == 0) ? 32'h0 : $urandom();
        end
        img[p] = 32'h0;
    endtask

    task automatic run_image(input bit poke, input string tag);
        int base = cap_n;
        int s0 = sync_err, p0 = phase_err, g0 = gap_err, i0 = idle_err;
        int t = 0;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R10 busy after start", {busy, done}, 2'b10);
        if (poke) begin
            repeat (300) @(posedge clk);
            #1;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            chk(busy == 1'b1, "R10 start ignored while busy", busy, 1);
        end
        while (!done && t < 40000) begin
            @(posedge clk); #1;
            t++;
        end
        chk(done == 1'b1, {"R7 done raised ", tag}, done, 1);
        chk(cap_n - base == exp_n, {"R7 word count ", tag}, cap_n - base, exp_n);
        chk(cap[base] == img[2], {"R5 first word is image word 2 ", tag}, cap[base], img[2]);
        for (int k = 0; k < exp_n && k < cap_n - base; k++)
            chk(cap[base + k] == exp_w[k], {"R2 R6 stream word ", tag}, cap[base + k], exp_w[k]);
        chk(sync_err == s0, {"R3 frame sync shape ", tag}, sync_err - s0, 0);
        chk(phase_err == p0, {"R8 clock phase width ", tag}, phase_err - p0, 0);
        chk(gap_err == g0, {"R9 inter-word gap ", tag}, gap_err - g0, 0);
        chk(idle_err == i0, {"R4 data idle low ", tag}, idle_err - i0, 0);
        repeat (60) @(posedge clk);
        #1;
        chk(cap_n - base == exp_n && done && !busy && !ser_clk,
            {"R7 nothing after closing word ", tag}, cap_n - base, exp_n);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk); #1;
        // R1 reset state
        chk({ser_clk, ser_sync, ser_data, busy, done} == 5'b0, "R1 reset outputs",
            {ser_clk, ser_sync, ser_data, busy, done}, 0);

        // directed: stream of only the closing word
        for (int a = 0; a < DEPTH; a++) img[a] = 32'hA5A5_0000 | 32'(a);
        img[0] = 32'h0000_0008;
        img[1] = 32'h0000_10F8;
        img[2] = 32'h0;
        load_image();
        run_image(1'b0, "zero-only");

        // directed: bit pattern corners, zero data word inside a block
        img[2] = 32'd5;
        img[3] = 32'h0080_9802;
        img[4] = 32'hFFFF_FFFF;
        img[5] = 32'h8000_0001;
        img[6] = 32'h0000_0000;
        img[7] = 32'h5A5A_5A5A;
        img[8] = 32'h7FFF_FFFE;
        img[9] = 32'd1;
        img[10] = 32'h0000_0000;
        img[11] = 32'h1234_5678;
        img[12] = 32'h0;
        load_image();
        run_image(1'b1, "corners");

        // random images
        for (int r = 0; r < 4; r++) begin
            random_image();
            load_image();
            run_image(r[0], "random");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule